// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives the clock for a contact smart card from a reference clock of up to 26 MHz. A 2-bit select code picks one of four ratios: divide by 1, 2, 4 or 8. The code may change at any moment, even while the card is being clocked. The block waits for a point where every candidate clock is low, and only there does it switch to the new ratio. The card never sees a shortened or stretched pulse.

A run/stop gate from the activation sequencer starts and stops the card clock. Like a ratio change, the gate takes effect only at that common low point. A stop therefore never cuts a pulse short, and a stopped clock always rests low. The select code and the gate are both synchronized to the reference clock inside the block. The asynchronous reset is also released through a synchronizer.

Top module: `card_clk_div`

## Requirements
- R1: The select code maps as follows: `00` selects divide by 8, `01` selects divide by 4, `11` selects divide by 2 and `10` selects divide by 1.
- R2: A new select code is applied only at the wrap of a free-running 3-bit phase counter. At that point all divided clocks are low. The new ratio governs the output no later than 12 reference cycles after the code changes.
- R3: No high pulse on `card_clk` is a runt. Every high pulse lasts exactly half a reference period, or exactly 1, 2 or 4 reference periods. This holds across ratio changes, starts and stops.
- R4: With a divided ratio selected and held, `card_clk` has a 50% duty cycle. For divide by N, both the high phase and the low phase last N/2 reference periods.
- R5: With divide by 1 selected, `card_clk` follows the reference clock: it is high while the reference is high and low while it is low.
- R6: After `run` falls, `card_clk` is low and stays low from at most 12 reference cycles onward. The last pulse keeps its full width.
- R7: After `run` rises, pulses resume within 14 reference cycles. The first pulse has full width.
- R8: While reset is asserted, and after reset until `run` is raised, `card_clk` is low. The reset ratio is divide by 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, the source of every card clock edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| ratio_sel | input | 2 | Division select code, asynchronous to `clk_ref` (mapping in R1) |
| run | input | 1 | Run/stop gate from the sequencer, asynchronous to `clk_ref` |
| card_clk | output | 1 | Gated and divided clock to the card |

## Verification
Faults in the phase counter or in the ratio register show up at the port as a high pulse of an illegal width. For example, a switch made off the wrap produces a 1.5-period pulse. Such a pulse appears within one divide-by-8 period of the bad switch, and the bench checks every pulse width continuously while random codes and gate changes are applied. A stuck or misrouted ratio register shows up in the first full period measured after a change, as a wrong high or low time. A fault in the divide-by-1 enable shows up as a half-period pulse outside divide-by-1, or as the output failing to stay low after a stop.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  // Largest division is 2**MAX_LOG2; the phase counter is this wide.
  localparam int MAX_LOG2 = 3;

  // Internal ratio encoding: value is log2 of the divisor.
  typedef enum logic [1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2,
    RATIO_8 = 2'd3
  } ratio_e;

  // External code to ratio: 00 -> /8, 01 -> /4, 11 -> /2, 10 -> /1.
  function automatic ratio_e decode_sel(input logic [1:0] code);
    case (code)
      2'b00:   decode_sel = RATIO_8;
      2'b01:   decode_sel = RATIO_4;
      2'b11:   decode_sel = RATIO_2;
      default: decode_sel = RATIO_1;
    endcase
  endfunction

endpackage

// File: rtl/ccd_sync.sv
// Multi-stage synchronizer, also used as a reset release synchronizer.
module ccd_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= RST_VAL;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ccd_phase_cnt.sv
// Free-running phase counter; its wrap is the common low point of all ratios.
module ccd_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             wrap
);

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    wrap   = (cnt_nx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  // R2: the counter advances by one every reference cycle
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ccd_out_gate.sv
// Output stage: full-rate path gated by an enable changed only while the
// reference is low, merged with the registered divided clock.
module ccd_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic full_req,
  input  logic div_q,
  output logic clk_out
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = full_req;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign clk_out = (clk & en_q) | div_q;

  // R5: the full-rate enable is never open unless divide by 1 is running
  a_r5_enable_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> full_req);

  // R3: the divided path and the full-rate path are never live together
  a_r3_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !div_q);

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       run,
  output logic       card_clk
);

  import ccd_pkg::*;

  localparam int CNT_W = MAX_LOG2;

  logic             rst_sync_n;
  logic [1:0]       sel_s;
  logic             run_s;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             wrap;

  ratio_e act_q, act_nx;
  logic   run_q, run_nx;
  logic   tap;
  logic   div_nx, div_q;
  logic   full_req;

  // Reset release synchronizer
  ccd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // Select code and gate synchronizers; select resets to the /8 code
  ccd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sel_sync (
    .clk   (clk_ref),
    .rst_n (rst_sync_n),
    .d     (ratio_sel),
    .q     (sel_s)
  );

  ccd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk   (clk_ref),
    .rst_n (rst_sync_n),
    .d     (run),
    .q     (run_s)
  );

  ccd_phase_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk    (clk_ref),
    .rst_n  (rst_sync_n),
    .cnt_q  (cnt_q),
    .cnt_nx (cnt_nx),
    .wrap   (wrap)
  );

  // Next state: ratio and gate are reloaded only at the counter wrap
  always_comb begin
    act_nx = act_q;
    run_nx = run_q;
    if (wrap) begin
      act_nx = decode_sel(sel_s);
      run_nx = run_s;
    end
    case (act_nx)
      RATIO_2: tap = cnt_nx[0];
      RATIO_4: tap = cnt_nx[1];
      RATIO_8: tap = cnt_nx[CNT_W-1];
      default: tap = 1'b0;
    endcase
    div_nx   = tap & run_nx;
    full_req = run_q & (act_q == RATIO_1);
  end

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q <= RATIO_8;
      run_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      act_q <= act_nx;
      run_q <= run_nx;
      div_q <= div_nx;
    end
  end

  ccd_out_gate u_gate (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .full_req (full_req),
    .div_q    (div_q),
    .clk_out  (card_clk)
  );

  // R2: the active ratio moves only on the counter wrap
  a_r2_ratio_moves_at_wrap: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (act_q != $past(act_q)) |-> (cnt_q == '0));

  // R2: the divided clock is low in the cycle that follows each wrap
  a_r2_low_after_wrap: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (cnt_q == '0) |-> !div_q);

  // R6: while stopped the divided path is quiet
  a_r6_stopped_quiet: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    !run_q |-> !div_q);

  // R5: the divided path is idle while divide by 1 is active
  a_r5_div1_no_divided: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (act_q == RATIO_1) |-> !div_q);

endmodule

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       run;
  logic       card_clk;

  always #5 clk = ~clk;

  card_clk_div dut (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .run       (run),
    .card_clk  (card_clk)
  );

  int n_checks = 0;
  int n_errs   = 0;

  // Monitor state, in half-reference-period samples
  bit   mon_on = 1'b0;
  logic lvl;
  int   run_len, last_hi, last_lo, rises;

  // Expected high (and low) duration in half periods for a code (R1, R4)
  function automatic int exp_halfs(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic bit legal_width(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take();
    logic s;
    s = card_clk;
    if (!mon_on) begin
      lvl = s; run_len = 1; rises = 0; last_hi = 0; last_lo = 0;
    end else if (s == lvl) begin
      run_len++;
    end else begin
      if (lvl) begin
        last_hi = run_len;
        // R3 and R7: every pulse, including the first after a start, has full width
        chk(legal_width(run_len), "R3 pulse width", run_len, 1);
      end else begin
        last_lo = run_len;
        rises++;
      end
      lvl = s;
      run_len = 1;
    end
  endtask

  // Samples in the high and in the low half of every reference period
  initial begin
    forever begin
      @(posedge clk); #2 take();
      #5 take();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  // R1, R2, R4, R5: apply a code, wait out the switch window, measure one period
  task automatic measure(input logic [1:0] code);
    int r0;
    ratio_sel = code;
    tick(14);
    r0 = rises;
    while (rises < r0 + 2) @(posedge clk);
    #4;
    chk(last_hi == exp_halfs(code), $sformatf("R1/R2 high time code=%b", code),
        last_hi, exp_halfs(code));
    chk(last_lo == exp_halfs(code), $sformatf("R4/R5 low time code=%b", code),
        last_lo, exp_halfs(code));
  endtask

  task automatic main();
    int r0;
    void'($urandom(32'd20251));
    rst_n = 1'b0; run = 1'b0; ratio_sel = 2'b00;
    tick(3);
    chk(card_clk == 1'b0, "R8 low in reset", card_clk, 0);
    rst_n = 1'b1;
    tick(4);
    mon_on = 1'b1;
    tick(24);
    chk(rises == 0, "R8 no pulses before run", rises, 0);

    run = 1'b1;
    r0 = rises;
    tick(14);
    chk(rises > r0, "R7 clock starts", rises - r0, 1);

    measure(2'b00);
    measure(2'b01);
    measure(2'b11);
    measure(2'b10);

    // R6: stop from divide by 1, then watch for silence
    run = 1'b0;
    tick(12);
    r0 = rises;
    for (int i = 0; i < 30; i++) begin
      chk(card_clk == 1'b0, "R6 held low", card_clk, 0);
      tick(1);
    end
    chk(rises == r0, "R6 no pulses while stopped", rises - r0, 0);

    // R7: restart directly into divide by 4
    ratio_sel = 2'b01;
    run = 1'b1;
    r0 = rises;
    tick(14);
    chk(rises > r0, "R7 clock restarts", rises - r0, 1);
    measure(2'b01);

    // R3: random codes and gate changes, widths checked by the monitor
    for (int i = 0; i < 400; i++) begin
      ratio_sel = 2'($urandom % 4);
      run = (($urandom % 8) != 0);
      tick(1 + int'($urandom % 30));
    end

    run = 1'b1;
    measure(2'b11);
    measure(2'b00);
  endtask

  initial begin
    fork
      main();
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule